// File: doc/BRIEF.md
# Cascaded Serial DAC Update Sequencer

This block drives a string of identical 12-bit serial-input converters that share one serial clock and one active-low load strobe. The converters are cascaded: each one's shift-register output feeds the next one's data input. A host hands the block one 12-bit code per converter in a single valid/ready transfer. The block then shifts all of the codes out, starting with the code for the converter at the far end of the string. It finishes with one low pulse on the load strobe, so every converter takes its new code at the same moment.

All serial timing comes from the system clock. The serial clock high and low phases, and the width of the load pulse, are set by cycle-count parameters. A check at elaboration rejects any setting that would break the converters' minimum timing. The block also reads back the bit stream that leaves the far end of the string. While a new update is shifted in, that stream holds the words left from the update before. The block compares the returned stream with those earlier words and reports the result once per update.

Top module: `chain_dac_ctrl`

## Requirements
- R1: After reset `ser_clk` is 0, `ser_load_n` is 1, `in_ready` is 1, and `upd_done` and `rb_valid` are 0. This also holds when reset is applied in the middle of an update.
- R2: The code for converter k is taken from `in_codes[12k+11:12k]`, where converter 0 sits next to the controller. The bit stream begins with converter N-1 and ends with converter 0. Within each code the most significant bit goes first. After an update, converter k holds its own code.
- R3: Every high phase of `ser_clk` lasts exactly HALF_CYC system cycles. Every low phase lasts at least HALF_CYC system cycles. The defaults give at least 350 ns per phase.
- R4: `ser_din` never changes while `ser_clk` is high. The first bit is presented HALF_CYC cycles before the first rising edge.
- R5: Each update makes exactly 12·N rising edges of `ser_clk`. It then drives `ser_load_n` low for exactly LOAD_CYC cycles. `ser_clk` stays low while `ser_load_n` is low.
- R6: `in_ready` is 0 from the cycle after a transfer is accepted until `ser_load_n` has returned high. `in_valid` and `in_codes` are ignored during that time.
- R7: `ser_dout` is sampled at each rising edge of `ser_clk`. In the cycle where `ser_load_n` returns high, `rb_valid` pulses. At the same time `rb_mismatch` shows whether the returned 12·N bits differ from the bits sent in the previous update. After reset there is no `rb_valid` pulse until one full update has finished.
- R8: `upd_done` is high for exactly one cycle, in the cycle where `ser_load_n` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Host offers a set of codes |
| in_ready | output | 1 | Sequencer is idle and will accept |
| in_codes | input | 12·N_DEV | One code per converter, converter k at bits [12k+11:12k] |
| ser_clk | output | 1 | Shared serial clock, idles low |
| ser_din | output | 1 | Serial data into the first converter |
| ser_load_n | output | 1 | Shared active-low load strobe, idles high |
| ser_dout | input | 1 | Serial data returned from the last converter |
| upd_done | output | 1 | One-cycle pulse when an update completes |
| rb_valid | output | 1 | One-cycle pulse when a readback comparison is reported |
| rb_mismatch | output | 1 | Result of the latest comparison, 1 means the returned bits differ |

## Verification
The assertions take it for granted that `ser_dout` changes only after this block raises `ser_clk`, just as a real converter's output shifts on that edge. They also assume the host keeps `in_codes` steady in the cycle it is accepted. The bench models the converter string as shift registers clocked by the rising edge of `ser_clk`, with the output latched when the strobe rises, so the returned bit always trails the sample point. The bench changes inputs only at falling system-clock edges. To corrupt the readback it inverts the returned stream for a whole update instead of touching the timing.

// File: rtl/chain_dac_pkg.sv
package chain_dac_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_LOAD
    } seq_state_e;

    // Smallest number of system cycles covering a span in nanoseconds
    function automatic int unsigned ns_to_cyc(input int unsigned span_ns,
                                              input int unsigned period_ns);
        return (span_ns + period_ns - 1) / period_ns;
    endfunction

endpackage

// File: rtl/chain_phase_timer.sv
module chain_phase_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] len,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (start)
            cnt <= len;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == W'(1));

    AST_TMR_NONZERO_LEN: assert property (@(posedge clk) disable iff (rst)
        start |-> (len != '0)); // R3

    AST_TMR_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (cnt == '0)); // R3
endmodule

// File: rtl/chain_shift_path.sv
module chain_shift_path #(
    parameter int unsigned TOTAL = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [TOTAL-1:0] load_bits,
    input  logic             shift,
    input  logic             sample,
    input  logic             ret_bit,
    input  logic             finish,
    output logic             din,
    output logic             mism
);
    logic [TOTAL-1:0] tx_sh;
    logic [TOTAL-1:0] sent_q;
    logic [TOTAL-1:0] prev_q;
    logic [TOTAL-1:0] rx_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            din    <= 1'b0;
            tx_sh  <= '0;
            sent_q <= '0;
            prev_q <= '0;
            rx_sh  <= '0;
        end else begin
            if (load) begin
                din    <= load_bits[TOTAL-1];
                tx_sh  <= {load_bits[TOTAL-2:0], 1'b0};
                sent_q <= load_bits;
            end
            if (shift) begin
                din   <= tx_sh[TOTAL-1];
                tx_sh <= {tx_sh[TOTAL-2:0], 1'b0};
            end
            if (sample)
                rx_sh <= {rx_sh[TOTAL-2:0], ret_bit};
            if (finish)
                prev_q <= sent_q;
        end
    end

    // The chain returns its former contents in the order they were sent
    assign mism = (rx_sh != prev_q);

    AST_SHIFT_NOT_WITH_LOAD: assert property (@(posedge clk) disable iff (rst)
        !(load && shift)); // R2

    AST_DIN_ONLY_ON_STEP: assert property (@(posedge clk) disable iff (rst)
        (!$past(load) && !$past(shift)) |-> $stable(din)); // R4
endmodule

// File: rtl/chain_dac_ctrl.sv
module chain_dac_ctrl
    import chain_dac_pkg::*;
#(
    parameter int unsigned N_DEV         = 2,
    parameter int unsigned WORD_W        = 12,
    parameter int unsigned CLK_PERIOD_NS = 8,
    parameter int unsigned HALF_CYC      = ns_to_cyc(360, CLK_PERIOD_NS),
    parameter int unsigned LOAD_CYC      = ns_to_cyc(160, CLK_PERIOD_NS)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic [N_DEV*WORD_W-1:0]   in_codes,
    output logic                      ser_clk,
    output logic                      ser_din,
    output logic                      ser_load_n,
    input  logic                      ser_dout,
    output logic                      upd_done,
    output logic                      rb_valid,
    output logic                      rb_mismatch
);
    localparam int unsigned TOTAL   = N_DEV * WORD_W;
    localparam int unsigned CNT_W   = $clog2(TOTAL + 1);
    localparam int unsigned TMR_MAX = (HALF_CYC > LOAD_CYC) ? HALF_CYC : LOAD_CYC;
    localparam int unsigned TMR_W   = $clog2(TMR_MAX + 1);

    // Elaboration-time timing limits of the converters
    initial begin
        AST_PHASE_MIN: assert (HALF_CYC * CLK_PERIOD_NS >= 350)
            else $error("serial clock phase shorter than 350 ns"); // R3
        AST_RATE_MAX: assert (2 * HALF_CYC * CLK_PERIOD_NS >= 715)
            else $error("serial clock faster than 1.4 MHz"); // R3
        AST_SETUP_MIN: assert (HALF_CYC * CLK_PERIOD_NS >= 100)
            else $error("data setup shorter than 100 ns"); // R4
        AST_STROBE_MIN: assert (LOAD_CYC * CLK_PERIOD_NS >= 150)
            else $error("load strobe shorter than 150 ns"); // R5
    end

    seq_state_e        state;
    logic [CNT_W-1:0]  bit_cnt;
    logic              have_prev;
    logic              accept;
    logic              last_bit;
    logic              tmr_start;
    logic [TMR_W-1:0]  tmr_len;
    logic              tmr_done;
    logic              step_shift;
    logic              step_sample;
    logic              step_finish;
    logic              cmp_mism;

    assign in_ready    = (state == ST_IDLE);
    assign accept      = in_valid && in_ready;
    assign last_bit    = (bit_cnt == CNT_W'(TOTAL));
    assign step_sample = (state == ST_LOW)  && tmr_done;
    assign step_shift  = (state == ST_HIGH) && tmr_done && !last_bit;
    assign step_finish = (state == ST_LOAD) && tmr_done;

    always_comb begin
        tmr_start = 1'b0;
        tmr_len   = TMR_W'(HALF_CYC);
        if (accept || step_sample || step_shift) begin
            tmr_start = 1'b1;
        end else if ((state == ST_HIGH) && tmr_done) begin
            tmr_start = 1'b1;
            tmr_len   = TMR_W'(LOAD_CYC);
        end
    end

    chain_phase_timer #(.W(TMR_W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (tmr_start),
        .len   (tmr_len),
        .done  (tmr_done)
    );

    chain_shift_path #(.TOTAL(TOTAL)) u_path (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .load_bits (in_codes),
        .shift     (step_shift),
        .sample    (step_sample),
        .ret_bit   (ser_dout),
        .finish    (step_finish),
        .din       (ser_din),
        .mism      (cmp_mism)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            bit_cnt     <= '0;
            ser_clk     <= 1'b0;
            ser_load_n  <= 1'b1;
            have_prev   <= 1'b0;
            upd_done    <= 1'b0;
            rb_valid    <= 1'b0;
            rb_mismatch <= 1'b0;
        end else begin
            upd_done <= 1'b0;
            rb_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        bit_cnt <= '0;
                        state   <= ST_LOW;
                    end
                end
                ST_LOW: begin
                    if (tmr_done) begin
                        ser_clk <= 1'b1;
                        bit_cnt <= bit_cnt + 1'b1;
                        state   <= ST_HIGH;
                    end
                end
                ST_HIGH: begin
                    if (tmr_done) begin
                        ser_clk <= 1'b0;
                        if (last_bit) begin
                            ser_load_n <= 1'b0;
                            state      <= ST_LOAD;
                        end else begin
                            state <= ST_LOW;
                        end
                    end
                end
                ST_LOAD: begin
                    if (tmr_done) begin
                        ser_load_n <= 1'b1;
                        upd_done   <= 1'b1;
                        have_prev  <= 1'b1;
                        if (have_prev) begin
                            rb_valid    <= 1'b1;
                            rb_mismatch <= cmp_mism;
                        end
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_STROBE_CLK_LOW: assert property (@(posedge clk) disable iff (rst)
        !ser_load_n |-> !ser_clk); // R5

    AST_STROBE_AFTER_ALL_BITS: assert property (@(posedge clk) disable iff (rst)
        $fell(ser_load_n) |-> (bit_cnt == CNT_W'(TOTAL))); // R5

    AST_DIN_STEADY_HIGH: assert property (@(posedge clk) disable iff (rst)
        ser_clk |-> $stable(ser_din)); // R4

    AST_BUSY_DURING_STROBE: assert property (@(posedge clk) disable iff (rst)
        (!ser_load_n || ser_clk) |-> !in_ready); // R6

    AST_RB_AT_STROBE_RISE: assert property (@(posedge clk) disable iff (rst)
        rb_valid |-> $rose(ser_load_n)); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        upd_done |=> !upd_done); // R8
endmodule

// File: tb/sim_chain_dac_ctrl.sv
module sim_chain_dac_ctrl;
    localparam int unsigned N     = 2;
    localparam int unsigned WW    = 12;
    localparam int unsigned TOT   = N * WW;
    localparam int unsigned HALF  = 45;
    localparam int unsigned LDW   = 20;
    localparam int unsigned NVEC  = 8;

    // {expect rb_valid, codes}
    localparam logic [TOT:0] VEC [NVEC] = '{
        {1'b0, 24'hFFF000},
        {1'b1, 24'h000FFF},
        {1'b1, 24'hA5A5A5},
        {1'b1, 24'h800001},
        {1'b1, 24'h123456},
        {1'b1, 24'hFFFFFF},
        {1'b1, 24'h7FF800},
        {1'b1, 24'h000000}
    };

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           in_valid = 1'b0;
    logic [TOT-1:0] in_codes = '0;
    logic           in_ready, ser_clk, ser_din, ser_load_n, ser_dout;
    logic           upd_done, rb_valid, rb_mismatch;
    logic           inj_flip = 1'b0;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    chain_dac_ctrl #(.N_DEV(N), .WORD_W(WW), .CLK_PERIOD_NS(8),
                     .HALF_CYC(HALF), .LOAD_CYC(LDW)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_codes(in_codes), .ser_clk(ser_clk), .ser_din(ser_din),
        .ser_load_n(ser_load_n), .ser_dout(ser_dout), .upd_done(upd_done),
        .rb_valid(rb_valid), .rb_mismatch(rb_mismatch)
    );

    // Converter string model
    logic [WW-1:0] dev_sr  [N] = '{default: '0};
    logic [WW-1:0] dev_out [N] = '{default: '0};

    always @(posedge ser_clk) begin
        dev_sr[0] <= {dev_sr[0][WW-2:0], ser_din};
        for (int k = 1; k < N; k++)
            dev_sr[k] <= {dev_sr[k][WW-2:0], dev_sr[k-1][WW-1]};
    end

    always @(posedge ser_load_n) begin
        for (int k = 0; k < N; k++)
            dev_out[k] <= dev_sr[k];
    end

    assign ser_dout = dev_sr[N-1][WW-1] ^ inj_flip;

    // Timing monitor
    logic p_clk = 1'b0, p_din = 1'b0, p_ld = 1'b1;
    int hi_run = 0, lo_run = 0, ld_run = 0, rises = 0;
    int v_clk = 0, v_din = 0, v_edge = 0, v_load = 0, v_rdy = 0;

    always @(negedge clk) begin
        cycles++;
        if (rst) begin
            hi_run = 0; lo_run = HALF; ld_run = 0; rises = 0;
        end else begin
            if (ser_clk && !p_clk) begin
                if (lo_run < HALF) v_clk++;
                if (!ser_load_n) v_edge++;
                rises++;
                hi_run = 0;
            end
            if (!ser_clk && p_clk) begin
                if (hi_run != HALF) v_clk++;
                lo_run = 0;
            end
            if (ser_din != p_din && ser_clk) v_din++;
            if (!ser_load_n && p_ld) begin
                if (rises != TOT) v_edge++;
                rises = 0;
                ld_run = 0;
            end
            if (ser_load_n && !p_ld && ld_run != LDW) v_load++;
            if (in_ready && (ser_clk || !ser_load_n)) v_rdy++;
            if (ser_clk) hi_run++; else lo_run++;
            if (!ser_load_n) ld_run++;
        end
        p_clk = ser_clk; p_din = ser_din; p_ld = ser_load_n;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 8000; i++) begin
            @(negedge clk);
            if (upd_done) begin
                seen = 1'b1;
                break;
            end
        end
    endtask

    task automatic run_update(input logic [TOT-1:0] codes, input bit exp_rb,
                              input bit exp_mm, input bit busy_junk);
        bit seen;
        logic [TOT-1:0] got;
        @(negedge clk);
        in_valid = 1'b1;
        in_codes = codes;
        @(negedge clk);
        in_valid = 1'b0;
        chk(!in_ready, "R6 ready low after accept", in_ready, 0);
        if (busy_junk) begin
            in_valid = 1'b1;
            in_codes = ~codes;
            repeat (600) @(negedge clk);
            in_valid = 1'b0;
        end
        wait_done(seen);
        chk(seen, "R8 update finished", seen, 1);
        chk(rb_valid == exp_rb, "R7 readback report", rb_valid, exp_rb);
        if (exp_rb)
            chk(rb_mismatch == exp_mm, "R7 mismatch flag", rb_mismatch, exp_mm);
        for (int k = 0; k < N; k++)
            got[k*WW +: WW] = dev_out[k];
        chk(got == codes, "R2 converter contents", got, codes);
        @(negedge clk);
        chk(!upd_done, "R8 done lasts one cycle", upd_done, 0);
        chk(in_ready, "R6 ready back after strobe", in_ready, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!ser_clk, "R1 clk idle", ser_clk, 0);
        chk(ser_load_n, "R1 strobe idle", ser_load_n, 1);
        chk(in_ready, "R1 ready", in_ready, 1);
        chk(!upd_done && !rb_valid, "R1 pulses low", {upd_done, rb_valid}, 0);
        rst = 1'b0;

        // Vector table: R2 ordering, R7 readback
        for (int v = 0; v < NVEC; v++)
            run_update(VEC[v][TOT-1:0], VEC[v][TOT], 1'b0, 1'b0);

        // R6: inputs offered while busy are ignored
        run_update(24'h3C96E1, 1'b1, 1'b0, 1'b1);
        repeat (100) @(negedge clk);
        chk(!ser_clk && ser_load_n, "R6 no extra update", {ser_clk, ser_load_n}, 1);

        // R7: corrupted return stream must be flagged, then clean again
        inj_flip = 1'b1;
        run_update(24'h0F0F0F, 1'b1, 1'b1, 1'b0);
        inj_flip = 1'b0;
        run_update(24'h5A5A5A, 1'b1, 1'b0, 1'b0);

        // R1: reset in mid-transfer, then R7 skip after reset
        @(negedge clk);
        in_valid = 1'b1;
        in_codes = 24'hDEADBE;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (700) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(!ser_clk && ser_load_n && in_ready, "R1 mid-transfer reset",
            {ser_clk, ser_load_n, in_ready}, 3'b011);
        rst = 1'b0;
        run_update(24'h456789, 1'b0, 1'b0, 1'b0);
        run_update(24'hABCDEF, 1'b1, 1'b0, 1'b0);

        // Monitored timing
        chk(v_clk == 0, "R3 clock phase widths", v_clk, 0);
        chk(v_din == 0, "R4 data steady while clock high", v_din, 0);
        chk(v_edge == 0, "R5 edge count and strobe quiet", v_edge, 0);
        chk(v_load == 0, "R5 strobe width", v_load, 0);
        chk(v_rdy == 0, "R6 ready while busy", v_rdy, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    always @(negedge clk) begin
        if (cycles > 190000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule